// File: doc/BRIEF.md
# Transfer Descriptor Chain Walker

This block drives the per-frame schedule of a serial-bus host controller. Software builds a singly linked chain of transfer descriptors in memory, and each record describes one bus transaction. The walker is started with the byte address of the first record. It reads that record word by word over a request/valid memory port whose latency is not fixed, then decodes it. It presents one transaction request to a downstream transaction engine and holds it until the engine signals completion. After that it either follows the record's link to the next entry or stops.

A record occupies four consecutive 32-bit words at a 16-byte-aligned base. Word 0 holds the link. Word 1 holds the target and mode bits. Word 2 holds the byte count. Word 3 is the buffer pointer. The walk stops when a record carries the end-of-chain flag, or when the frame boundary arrives. At a frame boundary the walker finishes whatever is already in flight and then goes idle without fetching further.

Top module: `td_chain_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_req`, `txn_req` and `list_done` are all low.
- R2: A `start` pulse while idle fetches the record at `head_addr` as four reads at byte offsets +0, +4, +8 and +12, in that order. Only one read is outstanding at a time. `mem_req` and `mem_addr` stay steady until `mem_valid` returns.
- R3: The transaction request carries these fields, decoded from the record: device address = word 1 bits [6:0]; byte count = word 2 bits [10:0]; buffer pointer = word 3 in full.
- R4: Word 1 bit 8 gives the direction, where 1 = IN (the host reads from the device) and 0 = OUT. Word 1 bit 9 gives the speed, where 1 = low speed and 0 = full speed. Both bits are passed through per record, so low-speed and full-speed records may share one chain.
- R5: `txn_req` and its fields stay steady until `txn_done` is sampled. No memory read is issued while a transaction is outstanding.
- R6: When word 0 bit 0 is clear, the next record is fetched from byte address {word 0 bits [31:4], 4'b0000} after `txn_done`.
- R7: When word 0 bit 0 is set, the walker goes idle on the `txn_done` edge and pulses `list_done` high for exactly one cycle. That pulse is the first cycle in which `busy` is low.
- R8: A `frame_end` pulse while busy lets any outstanding read or transaction complete and then stops the walk. No further read is requested and no `list_done` is pulsed. A `frame_end` pulse while idle has no effect on the next walk.
- R9: A `start` pulse while busy is ignored. The chain in progress completes unchanged.
- R10: Read data is taken only in a cycle where `mem_valid` is high, for any read latency of one or more cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `head_addr` (honoured only when idle) |
| head_addr | input | ADDR_W | Byte address of the first record |
| frame_end | input | 1 | Frame boundary; stop after work in flight |
| mem_req | output | 1 | Memory read request, held until `mem_valid` |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Read data |
| txn_req | output | 1 | Transaction request, held until `txn_done` |
| txn_dev | output | DEV_W | Target device address |
| txn_is_in | output | 1 | 1 = IN, 0 = OUT |
| txn_low_speed | output | 1 | 1 = low speed, 0 = full speed |
| txn_len | output | LEN_W | Byte count |
| txn_buf | output | ADDR_W | Memory buffer pointer |
| txn_done | input | 1 | Transaction engine completion |
| busy | output | 1 | A walk is in progress |
| list_done | output | 1 | One-cycle pulse when a chain ends at its flag |

## Verification
The first read request is due on the cycle after `start` is sampled. Each later read request is due on the cycle after the previous `mem_valid`. The transaction request is due on the cycle after the fourth `mem_valid`, and it drops on the cycle after `txn_done`. The `list_done` pulse or the first read of the next record is due on that same cycle. The bench's memory and engine models are clocked and answer only to these handshakes. Their latencies are varied from one to seven cycles, so the checks never depend on a fixed cycle count. A monitor logs read addresses, transactions, overlaps and `list_done` pulses as they occur. Each task compares those logs against the chain it wrote, after the walker reports idle.

// File: rtl/td_chain_walker.sv
module td_chain_walker #(
  parameter int ADDR_W = 32,
  parameter int DEV_W  = 7,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              frame_end,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [31:0]       mem_rdata,
  output logic              txn_req,
  output logic [DEV_W-1:0]  txn_dev,
  output logic              txn_is_in,
  output logic              txn_low_speed,
  output logic [LEN_W-1:0]  txn_len,
  output logic [ADDR_W-1:0] txn_buf,
  input  logic              txn_done,
  output logic              busy,
  output logic              list_done
);
  localparam int DIR_BIT = DEV_W + 1;
  localparam int SPD_BIT = DEV_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE} state_t;
  state_t st;

  logic [ADDR_W-1:0] cur;
  logic [1:0]        widx;
  logic [31:0]       w_link, w_ctl, w_len, w_buf;
  logic              stop_q;
  logic              stop_now;

  assign stop_now      = stop_q | frame_end;
  assign busy          = (st != S_IDLE);
  assign mem_req       = (st == S_FETCH);
  assign mem_addr      = cur + {{(ADDR_W-4){1'b0}}, widx, 2'b00};
  assign txn_req       = (st == S_ISSUE);
  assign txn_dev       = w_ctl[DEV_W-1:0];
  assign txn_is_in     = w_ctl[DIR_BIT];
  assign txn_low_speed = w_ctl[SPD_BIT];
  assign txn_len       = w_len[LEN_W-1:0];
  assign txn_buf       = w_buf[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur       <= '0;
      widx      <= '0;
      w_link    <= '0;
      w_ctl     <= '0;
      w_len     <= '0;
      w_buf     <= '0;
      stop_q    <= 1'b0;
      list_done <= 1'b0;
    end else begin
      list_done <= 1'b0;
      case (st)
        S_IDLE: begin
          stop_q <= 1'b0;
          if (start) begin
            cur  <= {head_addr[ADDR_W-1:4], 4'b0000};
            widx <= '0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (frame_end) stop_q <= 1'b1;
          if (mem_valid) begin
            case (widx)
              2'd0:    w_link <= mem_rdata;
              2'd1:    w_ctl  <= mem_rdata;
              2'd2:    w_len  <= mem_rdata;
              default: w_buf  <= mem_rdata;
            endcase
            if (widx == 2'd3 && !stop_now) st <= S_ISSUE;
            else if (stop_now)             st <= S_IDLE;
            widx <= widx + 2'd1;
          end
        end
        S_ISSUE: begin
          if (frame_end) stop_q <= 1'b1;
          if (txn_done) begin
            widx <= '0;
            if (w_link[0]) begin
              st        <= S_IDLE;
              list_done <= 1'b1;
            end else if (stop_now) begin
              st <= S_IDLE;
            end else begin
              cur <= {w_link[ADDR_W-1:4], 4'b0000};
              st  <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> !busy && !list_done); // R1
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R2
  AST_TXN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req && !txn_done |=> txn_req && $stable(txn_buf) && $stable(txn_len) && $stable(txn_dev)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && txn_req)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |-> !busy && $past(txn_done) && $past(txn_req)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done); // R7
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> mem_req && mem_addr == {$past(head_addr[ADDR_W-1:4]), 4'b0000}); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && mem_req && !mem_valid |=> $stable(mem_addr)); // R9
endmodule

// File: tb/td_chain_walker_tb.sv
module td_chain_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] head_addr = '0;
  logic        frame_end = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        txn_req;
  logic [6:0]  txn_dev;
  logic        txn_is_in, txn_low_speed;
  logic [10:0] txn_len;
  logic [31:0] txn_buf;
  logic        txn_done = 1'b0;
  logic        busy, list_done;

  always #2.5 clk = ~clk;

  td_chain_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr), .frame_end(frame_end),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .txn_req(txn_req), .txn_dev(txn_dev), .txn_is_in(txn_is_in), .txn_low_speed(txn_low_speed),
    .txn_len(txn_len), .txn_buf(txn_buf), .txn_done(txn_done), .busy(busy), .list_done(list_done)
  );

  int errors = 0;
  int checks = 0;
  int mem_lat = 1;
  int eng_lat = 1;
  logic clr = 1'b0;

  logic [31:0] mem [0:255];
  logic        m_pend = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0;

  int          rd_n = 0, lg_n = 0, ld_n = 0, ovl_n = 0;
  logic [31:0] rd_log [0:31];
  logic [6:0]  lg_dev [0:15];
  logic        lg_in  [0:15];
  logic        lg_low [0:15];
  logic [10:0] lg_len [0:15];
  logic [31:0] lg_buf [0:15];
  logic        e_pend = 1'b0;
  int          e_cnt = 0;

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (!rst_n || clr) begin
      m_pend <= 1'b0;
      rd_n   <= 0;
    end else if (mem_req && !mem_valid && !m_pend) begin
      if (rd_n < 32) rd_log[rd_n] <= mem_addr;
      rd_n   <= rd_n + 1;
      m_addr <= mem_addr;
      if (mem_lat <= 1) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem[mem_addr[9:2]];
      end else begin
        m_pend <= 1'b1;
        m_cnt  <= mem_lat - 1;
      end
    end else if (m_pend) begin
      if (m_cnt == 1) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem[m_addr[9:2]];
        m_pend    <= 1'b0;
      end else m_cnt <= m_cnt - 1;
    end
  end

  always @(posedge clk) begin
    txn_done <= 1'b0;
    if (!rst_n || clr) begin
      e_pend <= 1'b0;
      lg_n   <= 0;
      ld_n   <= 0;
      ovl_n  <= 0;
    end else begin
      if (list_done) ld_n <= ld_n + 1;
      if (mem_req && txn_req) ovl_n <= ovl_n + 1;
      if (txn_req && !txn_done && !e_pend) begin
        if (lg_n < 16) begin
          lg_dev[lg_n] <= txn_dev; lg_in[lg_n] <= txn_is_in; lg_low[lg_n] <= txn_low_speed;
          lg_len[lg_n] <= txn_len; lg_buf[lg_n] <= txn_buf;
        end
        lg_n   <= lg_n + 1;
        e_pend <= 1'b1;
        e_cnt  <= eng_lat;
      end else if (e_pend) begin
        if (e_cnt <= 1) begin
          txn_done <= 1'b1;
          e_pend   <= 1'b0;
        end else e_cnt <= e_cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_td(input logic [31:0] base, input logic [31:0] link, input logic term,
                        input logic [6:0] dev, input logic is_in, input logic low,
                        input logic [10:0] len, input logic [31:0] bufp);
    mem[base[9:2]]     = {link[31:4], 3'b000, term};
    mem[base[9:2] + 1] = {22'h2AAAAA, low, is_in, 1'b1, dev};
    mem[base[9:2] + 2] = {21'h155555, len};
    mem[base[9:2] + 3] = bufp;
  endtask

  task automatic clear_logs();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic kick(input logic [31:0] h);
    @(negedge clk); start = 1'b1; head_addr = h;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    @(negedge clk);
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(req, {31'd0, busy}, 32'd0);
  endtask

  task automatic chk_txn(input string req, input int i, input logic [6:0] dev, input logic is_in,
                         input logic low, input logic [10:0] len, input logic [31:0] bufp);
    chk(req, {25'd0, lg_dev[i]}, {25'd0, dev});
    chk(req, {30'd0, lg_in[i], lg_low[i]}, {30'd0, is_in, low});
    chk(req, {21'd0, lg_len[i]}, {21'd0, len});
    chk(req, lg_buf[i], bufp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 txn_req", {31'd0, txn_req}, 32'd0);
    chk("R1 list_done", {31'd0, list_done}, 32'd0);
  endtask

  task automatic t_single();
    mem_lat = 1; eng_lat = 1;
    put_td(32'h40, 32'h0, 1'b1, 7'd5, 1'b1, 1'b0, 11'd64, 32'h0000_1000);
    clear_logs();
    kick(32'h40);
    wait_idle("R7 idle");
    chk("R2 reads", rd_n, 4);
    for (int i = 0; i < 4; i++) chk("R2 read order", rd_log[i], 32'h40 + 4 * i);
    chk("R7 list_done pulses", ld_n, 1);
    chk("R3 txn count", lg_n, 1);
    chk_txn("R3 R4 single", 0, 7'd5, 1'b1, 1'b0, 11'd64, 32'h0000_1000);
  endtask

  task automatic t_chain();
    mem_lat = 4; eng_lat = 3;
    put_td(32'h80,  32'h100, 1'b0, 7'd1,   1'b1, 1'b1, 11'd8,    32'h0000_2000);
    put_td(32'h100, 32'h0C0, 1'b0, 7'd127, 1'b0, 1'b0, 11'd2047, 32'hDEAD_BEE0);
    put_td(32'h0C0, 32'h040, 1'b1, 7'd0,   1'b0, 1'b1, 11'd0,    32'h0000_0004);
    clear_logs();
    kick(32'h80);
    wait_idle("R6 idle");
    chk("R6 reads", rd_n, 12);
    chk("R6 second record", rd_log[4], 32'h100);
    chk("R6 third record", rd_log[8], 32'h0C0);
    chk("R6 txn count", lg_n, 3);
    chk_txn("R4 low IN", 0, 7'd1, 1'b1, 1'b1, 11'd8, 32'h0000_2000);
    chk_txn("R3 full OUT max", 1, 7'd127, 1'b0, 1'b0, 11'd2047, 32'hDEAD_BEE0);
    chk_txn("R4 low OUT", 2, 7'd0, 1'b0, 1'b1, 11'd0, 32'h0000_0004);
    chk("R7 one pulse", ld_n, 1);
    chk("R5 overlap", ovl_n, 0);
  endtask

  task automatic t_long_latency();
    mem_lat = 7; eng_lat = 5;
    clear_logs();
    kick(32'h80);
    wait_idle("R10 idle");
    chk("R10 reads", rd_n, 12);
    chk("R10 txn count", lg_n, 3);
    chk_txn("R10 data", 1, 7'd127, 1'b0, 1'b0, 11'd2047, 32'hDEAD_BEE0);
    chk("R5 overlap", ovl_n, 0);
  endtask

  task automatic t_busy_start();
    mem_lat = 3; eng_lat = 2;
    clear_logs();
    kick(32'h80);
    repeat (3) @(negedge clk);
    start = 1'b1; head_addr = 32'h40;
    @(negedge clk); start = 1'b0;
    while (lg_n < 2) @(negedge clk);
    start = 1'b1; head_addr = 32'h40;
    @(negedge clk); start = 1'b0;
    wait_idle("R9 idle");
    chk("R9 reads", rd_n, 12);
    chk("R9 head kept", rd_log[0], 32'h80);
    chk("R9 txn count", lg_n, 3);
    chk("R9 list_done", ld_n, 1);
  endtask

  task automatic t_frame_txn();
    mem_lat = 2; eng_lat = 6;
    clear_logs();
    kick(32'h80);
    while (lg_n < 1) @(negedge clk);
    frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    wait_idle("R8 idle after txn");
    chk("R8 txn finished only", lg_n, 1);
    chk("R8 no further reads", rd_n, 4);
    chk("R8 no list_done", ld_n, 0);
  endtask

  task automatic t_frame_fetch();
    mem_lat = 4; eng_lat = 1;
    clear_logs();
    kick(32'h80);
    while (rd_n < 2) @(negedge clk);
    frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    wait_idle("R8 idle after fetch");
    chk("R8 pending read only", rd_n, 2);
    chk("R8 no txn", lg_n, 0);
    chk("R8 no list_done", ld_n, 0);
  endtask

  task automatic t_frame_idle();
    mem_lat = 1; eng_lat = 1;
    clear_logs();
    frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    kick(32'h80);
    wait_idle("R8 idle pulse");
    chk("R8 walk after idle frame_end", lg_n, 3);
    chk("R8 list_done after idle frame_end", ld_n, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0000_0001;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_chain();
    t_long_latency();
    t_busy_start();
    t_frame_txn();
    t_frame_fetch();
    t_frame_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule